// File: doc/BRIEF.md
# Power-up strap latch controller

This block reads frequency-select strap levels from a set of shared pins while the supply is coming up. After that it hands the same pins over to clock output duty. It watches an asynchronous, active-low power-good strobe. The strobe passes through a synchronizer and then a low-level filter on the reference clock. On the first filtered low, the controller captures the strap pins into a host-frequency select code and raises a lock flag. One clock cycle later it enables the output drivers of the pins. From then on the strobe, the strap pins and the test-enable input have no effect on the captured values, until reset (which stands in for a power cycle).

A test-enable input that is high when capture takes place sends the controller into test clock mode. In that mode pin 0 acts as a control input. While pin 0 is high, the remaining pins drive the divided reference. While pin 0 is low, they are tristated. This selection is combinational and does not wait for a clock edge. The other strap levels no longer matter.

The state machine has four states:
- WAIT: the pins are inputs and the block waits for a filtered strobe low.
- ARM: capture has taken place and all drivers are still off.
- RUN: normal reference output on every pin.
- TEST: test clock output.

It has four transitions:
- capture: WAIT to ARM, on a filtered low.
- enable: ARM to RUN, when the captured test flag is 0.
- enter_test: ARM to TEST, when the captured test flag is 1.
- reset: any state back to WAIT.

Top module: `strap_latch_ctrl`

## Requirements
- R1: While reset is held, and after it is released, locked=0, test_mode=0, fsel=0 and every pin_oe bit is 0 until capture.
- R2: With the defaults (two synchronizer stages, two filter samples), take a strobe that goes low just before clock edge k and stays low. locked is 0 after edge k+2 and 1 after edge k+3.
- R3: A strobe low that the clock samples on only one edge never causes capture. A low sampled on two consecutive edges does cause capture.
- R4: At capture, fsel bit i takes the level of pin_in bit i.
- R5: After capture, changes on pwrgd_n, pin_in and test_en leave fsel, locked and test_mode unchanged until reset.
- R6: In normal mode pin_oe is all zeros in the first cycle after capture and all ones from the next cycle on. Each pin_out then follows ref_clk.
- R7: test_mode reads 1 from the capture cycle on exactly when test_en was 1 at the capture edge.
- R8: In test mode pin_oe[0] is 0. Every other pin_oe bit equals pin_in[0] combinationally, and those pins carry div_clk. pin_in[1] has no effect.
- R9: Only reset leaves test mode. It does so whatever level pin_in[1] holds, after which a new capture works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that samples the strobe |
| rst_n | input | 1 | Active-low reset (power cycle) |
| pwrgd_n | input | 1 | Asynchronous active-low power-good strobe |
| test_en | input | 1 | Test clock mode request, sampled at capture |
| ref_clk | input | 1 | Reference clock level driven out in normal mode |
| div_clk | input | 1 | Divided reference driven out in test mode |
| pin_in | input | NPIN | Levels seen on the shared pins |
| pin_out | output | NPIN | Values driven onto the shared pins |
| pin_oe | output | NPIN | Output enable for each shared pin |
| fsel | output | NPIN | Captured host-frequency select code |
| locked | output | 1 | High from capture until reset |
| test_mode | output | 1 | High from capture when test mode was requested |

## Verification
The bench builds the block with its defaults: two pins, two synchronizer stages and two filter samples. With this small configuration it can sweep all four strap codes against both test-enable levels. For each case it computes the capture edge and the driver-enable edge by counting cycles. The short filter makes the shortest ignored pulse and the shortest accepted pulse a single clock period apart, so both can be aimed precisely. Two pins are enough to show the control pin and the driven pin in test mode, and to drive both clock levels through the output mux.

// File: rtl/strap_pkg.sv
`timescale 1ns/1ps
package strap_pkg;
    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2,
        ST_TEST = 2'd3
    } strap_state_t;
endpackage

// File: rtl/strap_filter.sv
`timescale 1ns/1ps
module strap_filter #(
    parameter int SYNC_DEPTH = 2,
    parameter int FILT_LEN   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwrgd_n,
    output logic valid_low
);
    logic [SYNC_DEPTH-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_DEPTH-2:0], pwrgd_n};
    end

    generate
        if (FILT_LEN > 1) begin : g_hist
            localparam int HW = FILT_LEN - 1;
            logic [HW-1:0] hist_q;
            if (HW > 1) begin : g_wide
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) hist_q <= '1;
                    else        hist_q <= {hist_q[HW-2:0], sync_q[SYNC_DEPTH-1]};
                end
            end else begin : g_one
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) hist_q <= '1;
                    else        hist_q <= sync_q[SYNC_DEPTH-1];
                end
            end
            assign valid_low = !sync_q[SYNC_DEPTH-1] && !(|hist_q);
        end else begin : g_nohist
            assign valid_low = !sync_q[SYNC_DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/strap_fsm.sv
`timescale 1ns/1ps
module strap_fsm
    import strap_pkg::*;
#(
    parameter int NPIN = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid_low,
    input  logic            test_en,
    input  logic [NPIN-1:0] pin_in,
    output strap_state_t    state,
    output logic [NPIN-1:0] fsel,
    output logic            test_q
);
    strap_state_t state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_WAIT;
        else        state <= state_nx;
    end

    // transitions: capture, enable, enter_test
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WAIT: if (valid_low) state_nx = ST_ARM;
            ST_ARM:  state_nx = test_q ? ST_TEST : ST_RUN;
            ST_RUN:  state_nx = ST_RUN;
            ST_TEST: state_nx = ST_TEST;
        endcase
    end

    // one-shot capture of straps and the test request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsel   <= '0;
            test_q <= 1'b0;
        end else if (state == ST_WAIT && valid_low) begin
            fsel   <= pin_in;
            test_q <= test_en;
        end
    end
endmodule

// File: rtl/pin_drive.sv
`timescale 1ns/1ps
module pin_drive
    import strap_pkg::*;
#(
    parameter int NPIN = 2
) (
    input  strap_state_t    state,
    input  logic            ref_clk,
    input  logic            div_clk,
    input  logic            ctrl_pin,
    output logic [NPIN-1:0] pin_out,
    output logic [NPIN-1:0] pin_oe
);
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        always_comb begin
            pin_out[i] = 1'b0;
            pin_oe[i]  = 1'b0;
            unique case (state)
                ST_WAIT, ST_ARM: begin
                    pin_out[i] = 1'b0;
                    pin_oe[i]  = 1'b0;
                end
                ST_RUN: begin
                    pin_out[i] = ref_clk;
                    pin_oe[i]  = 1'b1;
                end
                ST_TEST: begin
                    pin_out[i] = (i == 0) ? 1'b0 : div_clk;
                    pin_oe[i]  = (i == 0) ? 1'b0 : ctrl_pin;
                end
            endcase
        end
    end
endmodule

// File: rtl/strap_latch_ctrl.sv
`timescale 1ns/1ps
module strap_latch_ctrl
    import strap_pkg::*;
#(
    parameter int NPIN       = 2,
    parameter int SYNC_DEPTH = 2,
    parameter int FILT_LEN   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwrgd_n,
    input  logic            test_en,
    input  logic            ref_clk,
    input  logic            div_clk,
    input  logic [NPIN-1:0] pin_in,
    output logic [NPIN-1:0] pin_out,
    output logic [NPIN-1:0] pin_oe,
    output logic [NPIN-1:0] fsel,
    output logic            locked,
    output logic            test_mode
);
    logic         valid_low;
    strap_state_t state;

    strap_filter #(.SYNC_DEPTH(SYNC_DEPTH), .FILT_LEN(FILT_LEN)) u_filt (
        .clk(clk), .rst_n(rst_n), .pwrgd_n(pwrgd_n), .valid_low(valid_low)
    );

    strap_fsm #(.NPIN(NPIN)) u_fsm (
        .clk(clk), .rst_n(rst_n), .valid_low(valid_low), .test_en(test_en),
        .pin_in(pin_in), .state(state), .fsel(fsel), .test_q(test_mode)
    );

    pin_drive #(.NPIN(NPIN)) u_drv (
        .state(state), .ref_clk(ref_clk), .div_clk(div_clk),
        .ctrl_pin(pin_in[0]), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    assign locked = (state != ST_WAIT);
endmodule

// File: rtl/strap_latch_chk.sv
`timescale 1ns/1ps
module strap_latch_chk #(
    parameter int NPIN = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            locked,
    input logic            test_mode,
    input logic            ctrl_pin,
    input logic [NPIN-1:0] pin_oe,
    input logic [NPIN-1:0] fsel
);
    assert_no_oe_unlocked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> pin_oe == '0);

    assert_locked_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    assert_fsel_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(fsel));

    assert_oe_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> pin_oe == '0);

    assert_test_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && test_mode) |=> test_mode);

    assert_test_ctrl_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |-> !pin_oe[0]);

    assert_test_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && locked && $past(locked)) |-> pin_oe[1] == ctrl_pin);
endmodule

bind strap_latch_ctrl strap_latch_chk #(.NPIN(NPIN)) u_chk (
    .clk(clk), .rst_n(rst_n), .locked(locked), .test_mode(test_mode),
    .ctrl_pin(pin_in[0]), .pin_oe(pin_oe), .fsel(fsel)
);

// File: tb/strap_latch_ctrl_test.sv
`timescale 1ns/1ps
module strap_latch_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwrgd_n = 1'b1;
    logic       test_en = 1'b0;
    logic       ref_clk = 1'b0;
    logic       div_clk = 1'b0;
    logic [1:0] pin_in = 2'b00;
    logic [1:0] pin_out, pin_oe, fsel;
    logic       locked, test_mode;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    strap_latch_ctrl uut (
        .clk(clk), .rst_n(rst_n), .pwrgd_n(pwrgd_n), .test_en(test_en),
        .ref_clk(ref_clk), .div_clk(div_clk), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .fsel(fsel),
        .locked(locked), .test_mode(test_mode)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic p1);
        @(negedge clk);
        rst_n = 1'b0; pwrgd_n = 1'b1; test_en = 1'b0; pin_in = {p1, 1'b0};
        tick(2);
        chk("R1 locked in reset", int'(locked), 0);
        chk("R1 test_mode in reset", int'(test_mode), 0);
        rst_n = 1'b1;
        tick(3);
        chk("R1 oe before capture", int'(pin_oe), 0);
        chk("R1 fsel before capture", int'(fsel), 0);
        chk("R1 locked before capture", int'(locked), 0);
    endtask

    // strobe low before edge k; lock after k+3, drivers after k+4
    task automatic capture(input int code, input bit tm);
        pin_in  = code[1:0];
        test_en = tm;
        pwrgd_n = 1'b0;
        tick(3);
        chk("R2 unlocked after k+2", int'(locked), 0);
        tick(1);
        chk("R2 locked after k+3", int'(locked), 1);
        chk("R6 oe off in capture cycle", int'(pin_oe), 0);
        chk("R4 fsel equals straps", int'(fsel), code);
        chk("R7 test_mode flag", int'(test_mode), int'(tm));
        tick(1);
        if (!tm) begin
            chk("R6 oe on in normal mode", int'(pin_oe), 3);
            ref_clk = 1'b1; #1;
            chk("R6 pins follow ref high", int'(pin_out), 3);
            ref_clk = 1'b0; #1;
            chk("R6 pins follow ref low", int'(pin_out), 0);
        end else begin
            chk("R8 control pin not driven", int'(pin_oe[0]), 0);
            chk("R8 driven pin follows ctrl", int'(pin_oe[1]), int'(pin_in[0]));
        end
    endtask

    initial begin
        for (int code = 0; code < 4; code++) begin
            for (int tm = 0; tm < 2; tm++) begin
                do_reset(1'b0);
                capture(code, tm[0]);
            end
        end

        // R3: a single sampled low is rejected, two are accepted
        do_reset(1'b0);
        pin_in = 2'b10;
        pwrgd_n = 1'b0; tick(1); pwrgd_n = 1'b1;
        tick(6);
        chk("R3 one-sample low ignored", int'(locked), 0);
        pwrgd_n = 1'b0; tick(2); pwrgd_n = 1'b1;
        tick(6);
        chk("R3 two-sample low captured", int'(locked), 1);
        chk("R3 captured code", int'(fsel), 2);

        // R5: changes after lock are ignored
        do_reset(1'b0);
        capture(1, 1'b0);
        for (int v = 0; v < 8; v++) begin
            pin_in = v[1:0]; test_en = v[2]; pwrgd_n = v[0];
            tick(2);
            chk("R5 fsel held", int'(fsel), 1);
            chk("R5 locked held", int'(locked), 1);
            chk("R5 test_mode held", int'(test_mode), 0);
            chk("R5 oe held", int'(pin_oe), 3);
        end

        // R8: asynchronous selection in test mode, pin 1 ignored
        do_reset(1'b0);
        capture(2, 1'b1);
        for (int v = 0; v < 4; v++) begin
            #1.2;
            pin_in = v[1:0];
            div_clk = v[1];
            #0.5;
            chk("R8 async oe of pin1", int'(pin_oe[1]), v & 1);
            chk("R8 pin0 tristated", int'(pin_oe[0]), 0);
            chk("R8 pin1 carries div", int'(pin_out[1]), (v >> 1) & 1);
            chk("R8 fsel unaffected by pin1", int'(fsel), 2);
            tick(1);
        end

        // R9: reset leaves test mode with pin 1 at either level
        for (int p = 0; p < 2; p++) begin
            do_reset(p[0]);
            chk("R9 test mode left by reset", int'(test_mode), 0);
            capture(3, 1'b0);
            chk("R9 normal after reset", int'(test_mode), 0);
            do_reset(p[0]);
            capture(0, 1'b1);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule